// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps time of day and calendar date as a chain of packed BCD counters. It holds hundredths of a second, seconds, minutes, hours (24-hour), day of week, date, month, year and a century flag. A one-cycle `tick` pulse, arriving at 100 Hz from an external prescaler, advances the hundredths counter. Each counter that wraps carries into the next one in the same clock cycle, so one tick can roll the whole calendar over.

A host sets any field through a load port that takes a 3-bit field address and a data byte. The host reads the time through a snapshot port. Raising `snap_req` for one cycle copies every field into a set of output registers on one clock edge. This gives a coherent reading that cannot tear across a carry. The block takes care of month lengths and the leap-year rule. A year is a leap year when its two-digit BCD value is divisible by four. A year rollover flips the century flag.

Top module: `bcd_calendar`

## Requirements
- R1: After synchronous reset the fields are hundredths 00, seconds 00, minutes 00, hours 00, century 0, day of week 01, date 01, month 01 and year 00. The snapshot outputs show these same values and `snap_vld` is 0.
- R2: Each accepted tick raises the hundredths by one in BCD (09 goes to 10). From 99 it wraps to 00 and carries into the seconds.
- R3: Seconds and minutes count 00 to 59 and hours count 00 to 23. On wrapping, each returns to 00 and carries into the next field. A carry out of the hours advances both the date and the day of week.
- R4: The day of week counts 01 to 07 and returns to 01 after 07.
- R5: The date wraps to 01 and advances the month after its last day. The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12. It is 30 for months 04, 06, 09 and 11. For month 02 it is 29 when the BCD year is divisible by four (00 counts) and 28 otherwise.
- R6: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and inverts the century flag.
- R7: With `ld_en` high, `ld_data` is written at the next edge into the field that `ld_sel` selects. The addresses are 0 for hundredths, 1 for seconds, 2 for minutes and 3 for hours, where bit 7 is the century flag and bits 5:0 are the hours. Address 4 is the day of week, 5 the date, 6 the month and 7 the year.
- R8: In a cycle with `ld_en` high, a tick is discarded entirely and no field advances.
- R9: A load to seconds (address 1) also clears the hundredths to 00.
- R10: A cycle with `snap_req` high copies every field, as it stood before that edge, into the snapshot outputs and raises `snap_vld` for the next cycle only. Without `snap_req` the snapshot outputs hold their values.
- R11: With `tick` and `ld_en` both low, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 100 Hz advance enable |
| ld_en | input | 1 | Host load strobe |
| ld_sel | input | 3 | Field address of the load |
| ld_data | input | 8 | Packed BCD load value |
| snap_req | input | 1 | Capture all fields into the snapshot outputs |
| snap_vld | output | 1 | Snapshot updated on the previous edge |
| snap_hund | output | 8 | Snapshot hundredths (BCD) |
| snap_sec | output | 8 | Snapshot seconds (BCD) |
| snap_min | output | 8 | Snapshot minutes (BCD) |
| snap_hour | output | 8 | Snapshot hours (BCD) |
| snap_cent | output | 1 | Snapshot century flag |
| snap_dow | output | 8 | Snapshot day of week (BCD) |
| snap_date | output | 8 | Snapshot date (BCD) |
| snap_month | output | 8 | Snapshot month (BCD) |
| snap_year | output | 8 | Snapshot year (BCD) |

## Verification
The range properties assume the host only ever loads legal packed BCD values that lie inside each field's range. A hours load, for example, must not exceed 23, and a date load must not be zero or above 31. The bench writes only such values. It also writes the month and year before it ticks across a month end, so the date limit in force is always the one under test. The priority and clear properties assume one load per cycle, which the driver task guarantees by issuing each load in a cycle of its own.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;

  localparam int BCD_W = 8;
  typedef logic [BCD_W-1:0] bcd_t;

  typedef struct packed {
    logic cent;
    bcd_t hour;
    bcd_t min;
    bcd_t sec;
    bcd_t hund;
    bcd_t dow;
    bcd_t date;
    bcd_t month;
    bcd_t year;
  } cal_fields_t;

  localparam cal_fields_t CAL_RESET = '{
    cent: 1'b0, hour: 8'h00, min: 8'h00, sec: 8'h00, hund: 8'h00,
    dow: 8'h01, date: 8'h01, month: 8'h01, year: 8'h00
  };

  // Upper limit of the sub-day chain, index 0 = hundredths .. 3 = hours
  function automatic bcd_t time_field_max(int idx);
    if (idx == 0) return 8'h99;
    if (idx == 3) return 8'h23;
    return 8'h59;
  endfunction

  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10*T + U is divisible by 4 exactly when 2*T[0] + U is
  function automatic logic year_is_leap(bcd_t y);
    logic [3:0] s;
    s = {2'b00, y[4], 1'b0} + y[3:0];
    return (s[1:0] == 2'b00);
  endfunction

  function automatic bcd_t month_last_day(bcd_t mo, bcd_t yr);
    case (mo)
      8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_wrap_ctr.sv
module bcd_wrap_ctr
  import bcd_calendar_pkg::*;
#(
  parameter bcd_t LO = 8'h00,
  parameter bcd_t HI = 8'h59
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic ld,
  input  bcd_t ld_val,
  output bcd_t q,
  output logic wrap
);

  assign wrap = inc && (q == HI);

  always_ff @(posedge clk) begin
    if (rst)       q <= LO;
    else if (ld)   q <= ld_val;
    else if (inc)  q <= wrap ? LO : bcd_inc(q);
  end

endmodule

// File: rtl/bcd_date_ctr.sv
module bcd_date_ctr
  import bcd_calendar_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic ld,
  input  bcd_t ld_val,
  input  bcd_t last_day,
  output bcd_t q,
  output logic wrap
);

  // >= keeps the counter sane if the month shrinks under a loaded date
  assign wrap = inc && (q >= last_day);

  always_ff @(posedge clk) begin
    if (rst)       q <= 8'h01;
    else if (ld)   q <= ld_val;
    else if (inc)  q <= wrap ? 8'h01 : bcd_inc(q);
  end

endmodule

// File: rtl/bcd_snap_reg.sv
module bcd_snap_reg #(
  parameter int            W   = 8,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         vld
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= RST;
      vld <= 1'b0;
    end else begin
      vld <= req;
      if (req) q <= d;
    end
  end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_calendar_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [7:0]       ld_data,
  input  logic             snap_req,
  output logic             snap_vld,
  output logic [7:0]       snap_hund,
  output logic [7:0]       snap_sec,
  output logic [7:0]       snap_min,
  output logic [7:0]       snap_hour,
  output logic             snap_cent,
  output logic [7:0]       snap_dow,
  output logic [7:0]       snap_date,
  output logic [7:0]       snap_month,
  output logic [7:0]       snap_year
);

  localparam int NUM_TIME = 4;
  localparam logic [SEL_W-1:0] A_HUND  = SEL_W'(0);
  localparam logic [SEL_W-1:0] A_SEC   = SEL_W'(1);
  localparam logic [SEL_W-1:0] A_MIN   = SEL_W'(2);
  localparam logic [SEL_W-1:0] A_HOUR  = SEL_W'(3);
  localparam logic [SEL_W-1:0] A_DOW   = SEL_W'(4);
  localparam logic [SEL_W-1:0] A_DATE  = SEL_W'(5);
  localparam logic [SEL_W-1:0] A_MONTH = SEL_W'(6);
  localparam logic [SEL_W-1:0] A_YEAR  = SEL_W'(7);
  localparam int SNAP_W = $bits(cal_fields_t);

  // Host load wins: a tick in a load cycle is dropped
  logic adv;
  assign adv = tick & ~ld_en;

  // Sub-day chain: hundredths, seconds, minutes, hours
  logic [NUM_TIME:0] carry;
  bcd_t tq   [NUM_TIME];
  bcd_t tval [NUM_TIME];
  logic tld  [NUM_TIME];

  assign carry[0] = adv;

  always_comb begin
    tld[0]  = ld_en && ((ld_sel == A_HUND) || (ld_sel == A_SEC));
    tval[0] = (ld_sel == A_SEC) ? 8'h00 : ld_data;
    tld[1]  = ld_en && (ld_sel == A_SEC);
    tval[1] = ld_data;
    tld[2]  = ld_en && (ld_sel == A_MIN);
    tval[2] = ld_data;
    tld[3]  = ld_en && (ld_sel == A_HOUR);
    tval[3] = {2'b00, ld_data[5:0]};
  end

  for (genvar i = 0; i < NUM_TIME; i++) begin : g_time
    bcd_wrap_ctr #(
      .LO (8'h00),
      .HI (time_field_max(i))
    ) u_field (
      .clk    (clk),
      .rst    (rst),
      .inc    (carry[i]),
      .ld     (tld[i]),
      .ld_val (tval[i]),
      .q      (tq[i]),
      .wrap   (carry[i+1])
    );
  end

  logic [7:0] hund_q, sec_q, min_q, hour_q;
  assign hund_q = tq[0];
  assign sec_q  = tq[1];
  assign min_q  = tq[2];
  assign hour_q = tq[3];

  logic day_adv;
  assign day_adv = carry[NUM_TIME];

  // Calendar part
  logic [7:0] dow_q, date_q, month_q, year_q;
  logic       cent_q;
  logic       dow_wrap_unused, mon_adv, yr_adv, cent_flip;
  bcd_t       last_day;

  assign last_day = month_last_day(month_q, year_q);

  bcd_wrap_ctr #(.LO(8'h01), .HI(8'h07)) u_dow (
    .clk (clk), .rst (rst), .inc (day_adv),
    .ld (ld_en && (ld_sel == A_DOW)), .ld_val (ld_data),
    .q (dow_q), .wrap (dow_wrap_unused)
  );

  bcd_date_ctr u_date (
    .clk (clk), .rst (rst), .inc (day_adv),
    .ld (ld_en && (ld_sel == A_DATE)), .ld_val (ld_data),
    .last_day (last_day), .q (date_q), .wrap (mon_adv)
  );

  bcd_wrap_ctr #(.LO(8'h01), .HI(8'h12)) u_month (
    .clk (clk), .rst (rst), .inc (mon_adv),
    .ld (ld_en && (ld_sel == A_MONTH)), .ld_val (ld_data),
    .q (month_q), .wrap (yr_adv)
  );

  bcd_wrap_ctr #(.LO(8'h00), .HI(8'h99)) u_year (
    .clk (clk), .rst (rst), .inc (yr_adv),
    .ld (ld_en && (ld_sel == A_YEAR)), .ld_val (ld_data),
    .q (year_q), .wrap (cent_flip)
  );

  always_ff @(posedge clk) begin
    if (rst)                               cent_q <= 1'b0;
    else if (ld_en && (ld_sel == A_HOUR))  cent_q <= ld_data[7];
    else if (cent_flip)                    cent_q <= ~cent_q;
  end

  // Coherent snapshot
  cal_fields_t live, snap;
  assign live = '{cent: cent_q, hour: hour_q, min: min_q, sec: sec_q,
                  hund: hund_q, dow: dow_q, date: date_q,
                  month: month_q, year: year_q};

  bcd_snap_reg #(.W(SNAP_W), .RST(CAL_RESET)) u_snap (
    .clk (clk), .rst (rst), .req (snap_req),
    .d (live), .q (snap), .vld (snap_vld)
  );

  assign snap_cent  = snap.cent;
  assign snap_hour  = snap.hour;
  assign snap_min   = snap.min;
  assign snap_sec   = snap.sec;
  assign snap_hund  = snap.hund;
  assign snap_dow   = snap.dow;
  assign snap_date  = snap.date;
  assign snap_month = snap.month;
  assign snap_year  = snap.year;

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             ld_en,
  input logic [SEL_W-1:0] ld_sel,
  input logic [7:0]       ld_data,
  input logic             snap_req,
  input logic             snap_vld,
  input logic [7:0]       snap_hund,
  input logic [7:0]       snap_year,
  input logic [7:0]       hund_q,
  input logic [7:0]       sec_q,
  input logic [7:0]       min_q,
  input logic [7:0]       hour_q,
  input logic [7:0]       dow_q,
  input logic [7:0]       date_q,
  input logic [7:0]       month_q,
  input logic [7:0]       year_q,
  input logic             cent_q
);

  // R2
  hund_bcd_chk: assert property (@(posedge clk) disable iff (rst)
    (hund_q[3:0] <= 4'd9) && (hund_q[7:4] <= 4'd9));

  // R3
  hour_range_chk: assert property (@(posedge clk) disable iff (rst)
    (hour_q <= 8'h23) && (hour_q[3:0] <= 4'd9) && (min_q <= 8'h59) && (sec_q <= 8'h59));

  // R4
  dow_range_chk: assert property (@(posedge clk) disable iff (rst)
    (dow_q >= 8'h01) && (dow_q <= 8'h07));

  // R5
  date_range_chk: assert property (@(posedge clk) disable iff (rst)
    (date_q >= 8'h01) && (date_q <= 8'h31) && (month_q >= 8'h01) && (month_q <= 8'h12));

  // R6
  century_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && (year_q != 8'h99)) |=> $stable(cent_q));

  // R7
  hund_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en && (ld_sel == SEL_W'(0))) |=> (hund_q == $past(ld_data)));

  // R8
  load_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en && tick && (ld_sel == SEL_W'(2))) |=> $stable(hund_q));

  // R9
  sec_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en && (ld_sel == SEL_W'(1))) |=> (hund_q == 8'h00));

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !snap_req |=> ($stable(snap_hund) && $stable(snap_year) && !snap_vld));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld_en) |=> $stable({hund_q, sec_q, min_q, hour_q, dow_q,
                                   date_q, month_q, year_q, cent_q}));

endmodule

bind bcd_calendar bcd_calendar_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       ld_en = 1'b0;
  logic [2:0] ld_sel = 3'd0;
  logic [7:0] ld_data = 8'h00;
  logic       snap_req = 1'b0;
  logic       snap_vld, snap_cent;
  logic [7:0] snap_hund, snap_sec, snap_min, snap_hour;
  logic [7:0] snap_dow, snap_date, snap_month, snap_year;

  always #2 clk = ~clk;

  bcd_calendar uut (
    .clk, .rst, .tick, .ld_en, .ld_sel, .ld_data, .snap_req, .snap_vld,
    .snap_hund, .snap_sec, .snap_min, .snap_hour, .snap_cent,
    .snap_dow, .snap_date, .snap_month, .snap_year
  );

  typedef struct packed {
    logic c;
    logic [7:0] h, m, s, hs, dw, dt, mo, yr;
  } view_t;

  view_t exp_q[$];
  string tag_q[$];
  int tests = 0;
  int fails = 0;

  function automatic view_t mk(logic c, logic [7:0] h, m, s, hs, dw, dt, mo, yr);
    return '{c, h, m, s, hs, dw, dt, mo, yr};
  endfunction

  function automatic view_t seen();
    return '{snap_cent, snap_hour, snap_min, snap_sec, snap_hund,
             snap_dow, snap_date, snap_month, snap_year};
  endfunction

  task automatic compare(view_t a, view_t e, string tag);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, a, e);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && snap_vld) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R10: unexpected snap_vld got 1 expected 0");
      end else begin
        compare(seen(), exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic drive(logic t, logic l, logic [2:0] s, logic [7:0] d, logic sn);
    @(negedge clk);
    tick = t; ld_en = l; ld_sel = s; ld_data = d; snap_req = sn;
  endtask

  task automatic idle();           drive(1'b0, 1'b0, 3'd0, 8'h00, 1'b0); endtask
  task automatic load(logic [2:0] s, logic [7:0] d); drive(1'b0, 1'b1, s, d, 1'b0); endtask
  task automatic step();           drive(1'b1, 1'b0, 3'd0, 8'h00, 1'b0); idle(); endtask

  task automatic set_all(logic c, logic [7:0] h, m, s, hs, dw, dt, mo, yr);
    load(3'd1, s); load(3'd2, m); load(3'd3, {c, 1'b0, h[5:0]});
    load(3'd4, dw); load(3'd5, dt); load(3'd6, mo); load(3'd7, yr);
    load(3'd0, hs); idle();
  endtask

  task automatic snap(view_t e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    drive(1'b0, 1'b0, 3'd0, 8'h00, 1'b1);
    idle(); idle();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    view_t hold;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state at the ports and through a snapshot
    compare(seen(), mk(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00), "R1 reset ports");
    tests++;
    if (snap_vld !== 1'b0) begin fails++; $display("FAIL R1: snap_vld got %b expected 0", snap_vld); end
    snap(mk(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00), "R1 reset snap");

    // R7 loads, then full rollover R3 R4 R6
    set_all(0, 8'h23, 8'h59, 8'h59, 8'h99, 8'h07, 8'h31, 8'h12, 8'h99);
    snap(mk(0, 8'h23, 8'h59, 8'h59, 8'h99, 8'h07, 8'h31, 8'h12, 8'h99), "R7 load all");
    step();
    snap(mk(1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00), "R6 R4 year rollover");
    set_all(1, 8'h23, 8'h59, 8'h59, 8'h99, 8'h03, 8'h31, 8'h12, 8'h99);
    step();
    snap(mk(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h01, 8'h00), "R6 century back");

    // R2 digit carry, R10 hold, R11 idle
    set_all(0, 8'h10, 8'h20, 8'h30, 8'h09, 8'h02, 8'h15, 8'h06, 8'h45);
    step();
    hold = mk(0, 8'h10, 8'h20, 8'h30, 8'h10, 8'h02, 8'h15, 8'h06, 8'h45);
    snap(hold, "R2 digit carry");
    step(); step(); step();
    compare(seen(), hold, "R10 snapshot held");
    snap(mk(0, 8'h10, 8'h20, 8'h30, 8'h13, 8'h02, 8'h15, 8'h06, 8'h45), "R2 three ticks");
    idle(); idle(); idle();
    snap(mk(0, 8'h10, 8'h20, 8'h30, 8'h13, 8'h02, 8'h15, 8'h06, 8'h45), "R11 no tick");

    // R3 minute carry into hours without date change
    set_all(0, 8'h08, 8'h59, 8'h59, 8'h99, 8'h05, 8'h20, 8'h07, 8'h30);
    step();
    snap(mk(0, 8'h09, 8'h00, 8'h00, 8'h00, 8'h05, 8'h20, 8'h07, 8'h30), "R3 hour carry");

    // R5 February and leap years
    set_all(0, 8'h23, 8'h59, 8'h59, 8'h99, 8'h01, 8'h28, 8'h02, 8'h23);
    step();
    snap(mk(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 8'h23), "R5 feb 23");
    set_all(0, 8'h23, 8'h59, 8'h59, 8'h99, 8'h01, 8'h28, 8'h02, 8'h24);
    step();
    snap(mk(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 8'h24), "R5 leap 24");
    set_all(0, 8'h23, 8'h59, 8'h59, 8'h99, 8'h02, 8'h29, 8'h02, 8'h24);
    step();
    snap(mk(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h24), "R5 leap end");
    set_all(0, 8'h23, 8'h59, 8'h59, 8'h99, 8'h04, 8'h28, 8'h02, 8'h00);
    step();
    snap(mk(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h05, 8'h29, 8'h02, 8'h00), "R5 leap 00");
    set_all(0, 8'h23, 8'h59, 8'h59, 8'h99, 8'h04, 8'h28, 8'h02, 8'h10);
    step();
    snap(mk(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h03, 8'h10), "R5 feb 10");
    set_all(0, 8'h23, 8'h59, 8'h59, 8'h99, 8'h04, 8'h28, 8'h02, 8'h12);
    step();
    snap(mk(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h05, 8'h29, 8'h02, 8'h12), "R5 leap 12");

    // R5 other month lengths
    set_all(0, 8'h23, 8'h59, 8'h59, 8'h99, 8'h06, 8'h30, 8'h04, 8'h50);
    step();
    snap(mk(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h07, 8'h01, 8'h05, 8'h50), "R5 april");
    set_all(0, 8'h23, 8'h59, 8'h59, 8'h99, 8'h07, 8'h30, 8'h11, 8'h50);
    step();
    snap(mk(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h12, 8'h50), "R5 R4 november");
    set_all(0, 8'h23, 8'h59, 8'h59, 8'h99, 8'h02, 8'h31, 8'h07, 8'h50);
    step();
    snap(mk(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h08, 8'h50), "R5 july");
    set_all(0, 8'h23, 8'h59, 8'h59, 8'h99, 8'h02, 8'h30, 8'h01, 8'h50);
    step();
    snap(mk(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h31, 8'h01, 8'h50), "R5 january 30");

    // R8 load beats tick, R9 seconds load clears hundredths
    set_all(0, 8'h05, 8'h06, 8'h07, 8'h50, 8'h03, 8'h10, 8'h10, 8'h10);
    drive(1'b1, 1'b1, 3'd2, 8'h33, 1'b0); idle();
    snap(mk(0, 8'h05, 8'h33, 8'h07, 8'h50, 8'h03, 8'h10, 8'h10, 8'h10), "R8 minute load with tick");
    drive(1'b1, 1'b1, 3'd0, 8'h77, 1'b0); idle();
    snap(mk(0, 8'h05, 8'h33, 8'h07, 8'h77, 8'h03, 8'h10, 8'h10, 8'h10), "R8 hundredths load with tick");
    load(3'd1, 8'h12); idle();
    snap(mk(0, 8'h05, 8'h33, 8'h12, 8'h00, 8'h03, 8'h10, 8'h10, 8'h10), "R9 seconds load");

    idle(); idle();
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10: pending snapshots got %0d expected 0", exp_q.size());
    end
    summary();
    $finish;
  end

endmodule